// File: doc/BRIEF.md
# SDRAM Refresh and Power-Exit Timer

This block sits beside an SDRAM command scheduler. It paces periodic auto-refresh by raising a refresh request once the average refresh interval has run out. The interval halves while the device runs hot. The block also tells the scheduler when commands may be issued again after a refresh, after leaving self-refresh and after leaving power-down. Two release outputs are kept, one for reads and one for every other command, because the two classes become legal at different times.

All limits are given in picoseconds or in clock cycles, and the block turns them into cycle counts from a clock-period parameter, rounding up. The wait after an active power-down exit depends on a mode bit captured at mode-register set and on the additive latency. A separate guard watches the clock-enable pin. It flags any high or low pulse that is shorter than the minimum width.

Top module: `sdr_refresh_exit_timer`

## Requirements
- R1: With `hot` low, `refresh_req` goes high exactly 975 cycles after the last reload at the default parameters (ceil(7.8 us / 8 ns)). A reload is a `ref_strobe`, a `sr_exit` or the release of reset.
- R2: Once high, `refresh_req` stays high until a `ref_strobe` is sampled. It is low after that edge.
- R3: While `hot` is high, the interval is 488 cycles (ceil(3.9 us / 8 ns)). If `hot` is sampled high while more than 488 cycles remain, the remaining count drops to 488 cycles from that edge.
- R4: After a `ref_strobe`, `nonread_ok` and `read_ok` are both low for exactly 14 cycles (ceil(105 ns / 8 ns)). The drop shows right after the edge that samples the strobe.
- R5: From the `sr_enter` edge until the `sr_exit` edge, both release outputs and `refresh_req` are low. After `sr_exit`, `nonread_ok` stays low for 15 cycles (ceil(115 ns / 8 ns)) and `read_ok` stays low for 200 cycles.
- R6: From `pd_enter` until exit, both release outputs are low. After `pd_exit_pre`, both stay low for 2 cycles.
- R7: After `pd_exit_act`, `nonread_ok` stays low for 2 cycles. `read_ok` stays low for 2 cycles in fast mode. In slow mode it stays low for 7 - `add_lat` cycles, with a floor of 1 cycle, so `add_lat` = 7 gives 1.
- R8: The mode bit changes only when `mrs_strobe` is high: `mrs_slow_bit` = 1 selects slow mode and 0 selects fast mode. At any other time `mrs_slow_bit` is ignored. Reset selects fast mode.
- R9: `cke_violation` is high for the one cycle after the edge that samples a change of `cke`, when the previous level was sampled on fewer than 3 consecutive edges.
- R10: After reset, `refresh_req` and `cke_violation` are low and both release outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_strobe | input | 1 | Auto-refresh issued this cycle |
| sr_enter | input | 1 | Self-refresh entry issued |
| sr_exit | input | 1 | Self-refresh exit issued |
| pd_enter | input | 1 | Power-down entry issued |
| pd_exit_pre | input | 1 | Exit from precharge power-down |
| pd_exit_act | input | 1 | Exit from active power-down |
| hot | input | 1 | Case temperature above the normal range |
| mrs_strobe | input | 1 | Mode-register set issued |
| mrs_slow_bit | input | 1 | Slow-exit select bit carried by the mode-register set |
| add_lat | input | 3 | Additive latency in cycles |
| cke | input | 1 | Clock-enable level driven to the device |
| refresh_req | output | 1 | Refresh due; held until a refresh is issued |
| nonread_ok | output | 1 | Commands other than reads may be issued |
| read_ok | output | 1 | Reads may be issued |
| cke_violation | output | 1 | Clock-enable pulse shorter than the minimum |

## Verification
The bench keeps its own count of cycles remaining for the refresh, non-read and read releases, and compares all four outputs on every cycle. A wrong refresh count shows as a `refresh_req` edge that comes one or more cycles off. With a 975-cycle interval, this can take up to one full interval to appear. A wrong exit count or a wrong captured mode bit shows as a release edge off by cycles, within at most 200 cycles of the exit. A wrong power state shows at once as a release output that is high while the device is in self-refresh or power-down. A wrong run-length count in the clock-enable guard shows on the first short pulse as a missing or extra flag.

// File: rtl/sdr_rpt_pkg.sv
package sdr_rpt_pkg;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_SELF = 2'd1,
        PWR_DOWN = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic refresh;
        logic sr_enter;
        logic sr_exit;
        logic pd_enter;
        logic pd_exit_pre;
        logic pd_exit_act;
    } cmd_evt_t;

    // Picosecond limit to whole cycles, rounded up.
    function automatic int unsigned ps_to_cyc(input int unsigned ps, input int unsigned clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Slow active power-down exit: base minus additive latency, never below one cycle.
    function automatic int unsigned slow_exit_cyc(input int unsigned base, input int unsigned al);
        if (al + 1 >= base) return 1;
        return base - al;
    endfunction

endpackage

// File: rtl/sdr_release_timer.sv
module sdr_release_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_cyc,
    input  logic         hold,
    output logic         ok
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ok  <= 1'b1;
        end else if (load) begin
            cnt <= load_cyc - W'(1);
            ok  <= 1'b0;
        end else if (hold) begin
            ok  <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
            ok  <= 1'b0;
        end else begin
            ok  <= 1'b1;
        end
    end

    // R4: a loaded wait always blocks the following cycle
    a_r4_load_blocks: assert property (@(posedge clk) disable iff (rst)
        load |=> !ok);

    // R6: low-power hold keeps the release low
    a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
        hold && !load |=> !ok);

    // R5: the wait counts down one per free cycle
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        !load && !hold && cnt != '0 |=> cnt == $past(cnt) - W'(1));

endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched #(
    parameter int unsigned IVL_COOL = 975,
    parameter int unsigned IVL_HOT  = 488
) (
    input  logic clk,
    input  logic rst,
    input  logic hot,
    input  logic reload,
    input  logic suspend,
    output logic req
);
    localparam int unsigned CW = $clog2(IVL_COOL);
    localparam logic [CW-1:0] COOL_M1 = CW'(IVL_COOL - 1);
    localparam logic [CW-1:0] HOT_M1  = CW'(IVL_HOT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || reload || suspend) begin
            cnt <= hot ? HOT_M1 : COOL_M1;
            req <= 1'b0;
        end else if (cnt == '0) begin
            req <= 1'b1;
        end else if (hot && cnt > HOT_M1) begin
            cnt <= HOT_M1;
        end else begin
            cnt <= cnt - CW'(1);
        end
    end

    // R2: a raised request waits for a refresh
    a_r2_req_sticky: assert property (@(posedge clk) disable iff (rst)
        req && !reload && !suspend |=> req);

    // R3: a hot cycle leaves no more than the short interval
    a_r3_hot_bound: assert property (@(posedge clk) disable iff (rst)
        hot && !req |=> cnt <= HOT_M1);

    // R1: no request before the count is spent
    a_r1_no_early: assert property (@(posedge clk) disable iff (rst)
        !req && cnt != '0 |=> !req);

endmodule

// File: rtl/sdr_cke_guard.sv
module sdr_cke_guard #(
    parameter int unsigned MIN_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic violation
);
    localparam int unsigned RW = $clog2(MIN_CYC + 1);
    localparam logic [RW-1:0] MIN_V = RW'(MIN_CYC);

    logic          level_q;
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q   <= cke;
            run       <= MIN_V;
            violation <= 1'b0;
        end else if (cke != level_q) begin
            violation <= (run < MIN_V);
            run       <= RW'(1);
            level_q   <= cke;
        end else begin
            violation <= 1'b0;
            if (run < MIN_V) run <= run + RW'(1);
        end
    end

    // R9: a flag only follows an edge on cke
    a_r9_flag_on_edge: assert property (@(posedge clk) disable iff (rst)
        violation |-> $past(cke) != $past(level_q));

    // R9: a steady level never raises the flag
    a_r9_steady_clean: assert property (@(posedge clk) disable iff (rst)
        cke == level_q |=> !violation);

endmodule

// File: rtl/sdr_refresh_exit_timer.sv
module sdr_refresh_exit_timer
    import sdr_rpt_pkg::*;
#(
    parameter int unsigned CLK_PS         = 8000,
    parameter int unsigned REFI_PS        = 7_800_000,
    parameter int unsigned RFC_PS         = 105_000,
    parameter int unsigned XS_EXTRA_PS    = 10_000,
    parameter int unsigned XSRD_CYC       = 200,
    parameter int unsigned XP_CYC         = 2,
    parameter int unsigned XARD_FAST_CYC  = 2,
    parameter int unsigned XARD_SLOW_BASE = 7,
    parameter int unsigned CKE_MIN_CYC    = 3,
    parameter int unsigned AL_W           = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_strobe,
    input  logic            sr_enter,
    input  logic            sr_exit,
    input  logic            pd_enter,
    input  logic            pd_exit_pre,
    input  logic            pd_exit_act,
    input  logic            hot,
    input  logic            mrs_strobe,
    input  logic            mrs_slow_bit,
    input  logic [AL_W-1:0] add_lat,
    input  logic            cke,
    output logic            refresh_req,
    output logic            nonread_ok,
    output logic            read_ok,
    output logic            cke_violation
);
    localparam int unsigned IVL_COOL  = ps_to_cyc(REFI_PS, CLK_PS);
    localparam int unsigned IVL_HOT   = ps_to_cyc(REFI_PS / 2, CLK_PS);
    localparam int unsigned RFC_CYC   = ps_to_cyc(RFC_PS, CLK_PS);
    localparam int unsigned XSNR_CYC  = ps_to_cyc(RFC_PS + XS_EXTRA_PS, CLK_PS);
    localparam int unsigned WAIT_MAX  = max_u(max_u(max_u(RFC_CYC, XSNR_CYC), max_u(XSRD_CYC, XP_CYC)),
                                              max_u(XARD_FAST_CYC, XARD_SLOW_BASE));
    localparam int unsigned WAIT_W    = $clog2(WAIT_MAX + 1);
    localparam int unsigned N_REL     = 2;  // index 0: non-read, 1: read

    cmd_evt_t   evt;
    pwr_state_e state;
    logic       slow_mode;
    logic       hold;
    logic       any_exit;
    logic [WAIT_W-1:0] slow_cyc;
    logic [WAIT_W-1:0] rel_cyc [N_REL];
    logic [N_REL-1:0]  rel_ok;

    always_comb begin
        evt.refresh     = ref_strobe;
        evt.sr_enter    = sr_enter;
        evt.sr_exit     = sr_exit;
        evt.pd_enter    = pd_enter;
        evt.pd_exit_pre = pd_exit_pre;
        evt.pd_exit_act = pd_exit_act;
    end

    // Power state and captured exit mode
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PWR_ON;
            slow_mode <= 1'b0;
        end else begin
            if (mrs_strobe) slow_mode <= mrs_slow_bit;
            unique case (state)
                PWR_ON: begin
                    if (evt.sr_enter)      state <= PWR_SELF;
                    else if (evt.pd_enter) state <= PWR_DOWN;
                end
                PWR_SELF: if (evt.sr_exit) state <= PWR_ON;
                PWR_DOWN: if (evt.pd_exit_pre || evt.pd_exit_act) state <= PWR_ON;
                default:  state <= PWR_ON;
            endcase
        end
    end

    assign hold     = (state != PWR_ON) || evt.sr_enter || evt.pd_enter;
    assign any_exit = evt.refresh || evt.sr_exit || evt.pd_exit_pre || evt.pd_exit_act;
    assign slow_cyc = WAIT_W'(slow_exit_cyc(XARD_SLOW_BASE, 32'(add_lat)));

    always_comb begin
        if (evt.sr_exit) begin
            rel_cyc[0] = WAIT_W'(XSNR_CYC);
            rel_cyc[1] = WAIT_W'(XSRD_CYC);
        end else if (evt.refresh) begin
            rel_cyc[0] = WAIT_W'(RFC_CYC);
            rel_cyc[1] = WAIT_W'(RFC_CYC);
        end else if (evt.pd_exit_act) begin
            rel_cyc[0] = WAIT_W'(XP_CYC);
            rel_cyc[1] = slow_mode ? slow_cyc : WAIT_W'(XARD_FAST_CYC);
        end else begin
            rel_cyc[0] = WAIT_W'(XP_CYC);
            rel_cyc[1] = WAIT_W'(XP_CYC);
        end
    end

    for (genvar g = 0; g < N_REL; g++) begin : g_rel
        sdr_release_timer #(.W(WAIT_W)) u_timer (
            .clk      (clk),
            .rst      (rst),
            .load     (any_exit),
            .load_cyc (rel_cyc[g]),
            .hold     (hold),
            .ok       (rel_ok[g])
        );
    end

    assign nonread_ok = rel_ok[0];
    assign read_ok    = rel_ok[1];

    sdr_refresh_sched #(.IVL_COOL(IVL_COOL), .IVL_HOT(IVL_HOT)) u_sched (
        .clk     (clk),
        .rst     (rst),
        .hot     (hot),
        .reload  (evt.refresh || evt.sr_exit),
        .suspend (evt.sr_enter || state == PWR_SELF),
        .req     (refresh_req)
    );

    sdr_cke_guard #(.MIN_CYC(CKE_MIN_CYC)) u_cke (
        .clk       (clk),
        .rst       (rst),
        .cke       (cke),
        .violation (cke_violation)
    );

    // R5: nothing is released while in a low-power state
    a_r5_blocked_low_power: assert property (@(posedge clk) disable iff (rst)
        state != PWR_ON |-> !nonread_ok && !read_ok);

    // R5: no refresh request during self-refresh
    a_r5_no_req_in_self: assert property (@(posedge clk) disable iff (rst)
        state == PWR_SELF |-> !refresh_req);

    // R8: the mode bit moves only on a mode-register set
    a_r8_mode_stable: assert property (@(posedge clk) disable iff (rst)
        !mrs_strobe |=> $stable(slow_mode));

    // R4: at most one command event per cycle is expected
    a_r4_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt));

endmodule

// File: tb/sdr_refresh_exit_timer_tb.sv
module sdr_refresh_exit_timer_tb;

    localparam int CLK_PS   = 8000;
    localparam int T_COOL   = (7_800_000 + CLK_PS - 1) / CLK_PS;
    localparam int T_HOT    = (3_900_000 + CLK_PS - 1) / CLK_PS;
    localparam int T_RFC    = (105_000 + CLK_PS - 1) / CLK_PS;
    localparam int T_XSNR   = (115_000 + CLK_PS - 1) / CLK_PS;
    localparam int T_XSRD   = 200;
    localparam int T_XP     = 2;
    localparam int T_FAST   = 2;
    localparam int CKE_MIN  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_strobe = 0, sr_enter = 0, sr_exit = 0, pd_enter = 0;
    logic pd_exit_pre = 0, pd_exit_act = 0, hot = 0, mrs_strobe = 0, mrs_slow_bit = 0;
    logic [2:0] add_lat = 3'd0;
    logic cke = 1'b1;
    logic refresh_req, nonread_ok, read_ok, cke_violation;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4ns clk = ~clk;

    sdr_refresh_exit_timer u_dut (
        .clk(clk), .rst(rst), .ref_strobe(ref_strobe), .sr_enter(sr_enter),
        .sr_exit(sr_exit), .pd_enter(pd_enter), .pd_exit_pre(pd_exit_pre),
        .pd_exit_act(pd_exit_act), .hot(hot), .mrs_strobe(mrs_strobe),
        .mrs_slow_bit(mrs_slow_bit), .add_lat(add_lat), .cke(cke),
        .refresh_req(refresh_req), .nonread_ok(nonread_ok), .read_ok(read_ok),
        .cke_violation(cke_violation)
    );

    // Reference: cycles left before each output is due, from the requirements
    int m_ref_left, m_nr_left, m_rd_left, m_st, m_run;
    bit m_slow, m_prev, m_viol;

    function automatic int rd_wait_act(input bit slow, input int al);
        if (!slow) return T_FAST;
        return (7 - al < 1) ? 1 : 7 - al;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ref_left <= hot ? T_HOT : T_COOL;
            m_nr_left <= 0; m_rd_left <= 0; m_st <= 0; m_slow <= 0;
            m_prev <= cke; m_run <= CKE_MIN; m_viol <= 0;
        end else begin
            if (ref_strobe || sr_exit || sr_enter || m_st == 1)
                m_ref_left <= hot ? T_HOT : T_COOL;
            else if (m_ref_left > 0)
                m_ref_left <= (hot && m_ref_left - 1 > T_HOT) ? T_HOT : m_ref_left - 1;

            if (ref_strobe)       begin m_nr_left <= T_RFC;  m_rd_left <= T_RFC;  end
            else if (sr_exit)     begin m_nr_left <= T_XSNR; m_rd_left <= T_XSRD; end
            else if (pd_exit_pre) begin m_nr_left <= T_XP;   m_rd_left <= T_XP;   end
            else if (pd_exit_act) begin m_nr_left <= T_XP;   m_rd_left <= rd_wait_act(m_slow, int'(add_lat)); end
            else begin
                if (m_nr_left > 0) m_nr_left <= m_nr_left - 1;
                if (m_rd_left > 0) m_rd_left <= m_rd_left - 1;
            end

            if (sr_enter) m_st <= 1;
            else if (pd_enter) m_st <= 2;
            else if (sr_exit || pd_exit_pre || pd_exit_act) m_st <= 0;

            if (mrs_strobe) m_slow <= mrs_slow_bit;

            if (cke != m_prev) begin
                m_viol <= (m_run < CKE_MIN); m_run <= 1; m_prev <= cke;
            end else begin
                m_viol <= 0;
                if (m_run < CKE_MIN) m_run <= m_run + 1;
            end
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: outputs sampled at the falling edge, then strobes cleared
    task automatic step();
        @(negedge clk);
        if (!rst) begin
            check_bit(refresh_req, (m_ref_left == 0) && (m_st != 1), "R1 R2 R3 refresh_req");
            check_bit(nonread_ok, (m_nr_left == 0) && (m_st == 0), "R4 R6 nonread_ok");
            check_bit(read_ok, (m_rd_left == 0) && (m_st == 0), "R5 R7 read_ok");
            check_bit(cke_violation, m_viol, "R9 cke_violation");
        end
        ref_strobe = 0; sr_enter = 0; sr_exit = 0; pd_enter = 0;
        pd_exit_pre = 0; pd_exit_act = 0; mrs_strobe = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic measure_release(output int nr, output int rd);
        nr = 0; rd = 0;
        for (int i = 0; i < 400; i++) begin
            step();
            if (!nonread_ok) nr++;
            if (!read_ok) rd++;
            if (nonread_ok && read_ok) break;
        end
    endtask

    task automatic count_req_low(output int n);
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            step();
            if (refresh_req) break;
            n++;
        end
    endtask

    task automatic act_pd_exit(input int al, output int nr, output int rd);
        pd_enter = 1; step(); idle(3);
        add_lat = 3'(al); pd_exit_act = 1;
        measure_release(nr, rd);
    endtask

    initial begin
        #(8ns * 190000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int nr, rd, n;
        void'($urandom(32'h5eed_0417));
        idle(3);
        @(negedge clk); rst = 0;
        step();
        // R10: reset state
        check_bit(refresh_req, 1'b0, "R10 req after reset");
        check_bit(nonread_ok, 1'b1, "R10 nonread after reset");
        check_bit(read_ok, 1'b1, "R10 read after reset");
        check_bit(cke_violation, 1'b0, "R10 flag after reset");

        // R4 and R1: refresh wait and full interval
        ref_strobe = 1; measure_release(nr, rd);
        check_int(nr, T_RFC, "R4 nonread wait after refresh");
        check_int(rd, T_RFC, "R4 read wait after refresh");
        ref_strobe = 1; count_req_low(n);
        check_int(n, T_COOL, "R1 cool interval");
        // R2: request holds, then clears on refresh
        idle(300);
        check_bit(refresh_req, 1'b1, "R2 request held");
        ref_strobe = 1; step();
        check_bit(refresh_req, 1'b0, "R2 request cleared");

        // R3: hot interval and mid-interval clamp
        hot = 1; ref_strobe = 1; count_req_low(n);
        check_int(n, T_HOT, "R3 hot interval");
        hot = 0; ref_strobe = 1; step(); idle(100);
        hot = 1; count_req_low(n);
        check_int(n, T_HOT, "R3 clamp on hot rise");
        hot = 0; ref_strobe = 1; step();

        // R5: self-refresh
        sr_enter = 1; step();
        check_bit(nonread_ok, 1'b0, "R5 blocked in self-refresh");
        idle(1500);
        check_bit(refresh_req, 1'b0, "R5 no request in self-refresh");
        sr_exit = 1; measure_release(nr, rd);
        check_int(nr, T_XSNR, "R5 nonread wait after self-refresh");
        check_int(rd, T_XSRD, "R5 read wait after self-refresh");

        // R6: precharge power-down
        pd_enter = 1; step(); idle(5);
        check_bit(read_ok, 1'b0, "R6 blocked in power-down");
        pd_exit_pre = 1; measure_release(nr, rd);
        check_int(nr, T_XP, "R6 nonread wait");
        check_int(rd, T_XP, "R6 read wait");

        // R7 and R8: active power-down exits
        act_pd_exit(5, nr, rd);
        check_int(nr, T_XP, "R7 nonread wait active exit");
        check_int(rd, T_FAST, "R7 fast read wait");
        mrs_slow_bit = 1; mrs_strobe = 1; step();
        act_pd_exit(3, nr, rd);
        check_int(rd, 4, "R7 slow read wait al=3");
        act_pd_exit(7, nr, rd);
        check_int(rd, 1, "R7 slow read floor al=7");
        mrs_slow_bit = 0; step();
        act_pd_exit(0, nr, rd);
        check_int(rd, 7, "R8 bit ignored without strobe");
        mrs_strobe = 1; step();
        act_pd_exit(0, nr, rd);
        check_int(rd, T_FAST, "R8 back to fast mode");

        // R9: clock-enable pulse widths
        cke = 1; idle(5);
        cke = 0; step(); step();
        cke = 1; step();
        check_bit(cke_violation, 1'b1, "R9 short low pulse flagged");
        step();
        check_bit(cke_violation, 1'b0, "R9 flag lasts one cycle");
        step();
        cke = 0; step();
        check_bit(cke_violation, 1'b0, "R9 three-cycle high accepted");
        idle(4);

        // Random phase, compared every cycle against the reference
        for (int i = 0; i < 15000; i++) begin
            int r;
            r = $urandom % 1000;
            if (m_st == 0) begin
                if (refresh_req && r < 60) ref_strobe = 1;
                else if (r < 62) ref_strobe = 1;
                else if (r < 65) sr_enter = 1;
                else if (r < 71) pd_enter = 1;
                else if (r < 76) begin mrs_strobe = 1; mrs_slow_bit = 1'($urandom); end
                else if (r < 80) mrs_slow_bit = 1'($urandom);
            end else if (m_st == 1) begin
                if (r < 15) sr_exit = 1;
            end else begin
                if (r < 40) begin
                    if ($urandom % 2) pd_exit_act = 1; else pd_exit_pre = 1;
                end
            end
            if (r >= 990) hot = ~hot;
            if (($urandom % 8) == 0) add_lat = 3'($urandom);
            if (($urandom % 5) == 0) cke = ~cke;
            step();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule